// File: doc/BRIEF.md
# Compressed Trace Probe

This block is an on-chip probe for watching internal signals without outside debug equipment. It registers up to fifteen probe lines and a trigger line on its clock. Once armed by a host command, it waits for a rising edge on the registered trigger. From that edge on, it writes the probe history into an internal trace buffer.

The history is compressed. A change of value is stored as a literal entry. A span of repeated samples is stored as one count entry instead of one entry per sample, so a small buffer can cover long quiet stretches.

The host works in a trigger-then-poll loop:
- It arms the probe.
- It polls the status outputs until the buffer reports full, or it aborts.
- It rewinds the read pointer.
- It pulls the entries out one per cycle through the read port.

The host interface shares the capture clock.

Top module: `trace_probe`

## Requirements
- R1: Every buffer entry is 16 bits wide. When bit 15 is 0, bits 14:0 hold a probe sample, zero-extended from the probe width. When bit 15 is 1, bits 14:0 count samples that repeated the preceding value and were not written on their own.
- R2: The probe and trigger inputs are registered before use. The first entry after a trigger rising edge is a literal of the probe value sampled on the same clock edge as the high trigger.
- R3: After the first entry, a sample equal to the previous one adds one to a pending run count and writes nothing. A differing sample writes the pending run entry, when its count is nonzero, and then a literal of the new value. Both entries are written in the same cycle.
- R4: A pending run that has reached RUN_MAX is written as a count entry of RUN_MAX when a further equal sample arrives. Counting then restarts at 1.
- R5: The command code is cmd_op 1, qualified by cmd_valid, for arm. Arm clears the entry count, raises busy and lowers done. No entry is written until a rising edge of the registered trigger. A trigger that is already high when arm is given does not start capture until it falls and rises again.
- R6: Capture stops once count reaches DEPTH. Done is then 1, busy is 0, and later samples write nothing. If a change needs two entries while only one slot remains, only the run entry is written.
- R7: The command code is cmd_op 2 for abort. Abort returns the block to idle and discards a pending run that has not been written. The entries already written and the count are kept.
- R8: rd_data shows the entry at the read pointer. Each cycle with rd_en high advances the pointer by one. Command code cmd_op 3 sets the pointer to zero, and it takes priority over rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture and host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_in | input | W | Probed signals |
| trig_in | input | 1 | Trigger line, acted on at its rising edge |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 1 arm, 2 abort, 3 rewind read pointer |
| rd_en | input | 1 | Advance the read pointer |
| rd_data | output | 16 | Entry at the read pointer |
| busy | output | 1 | Armed or capturing |
| done | output | 1 | Buffer full, capture stopped |
| count | output | $clog2(DEPTH+1) | Number of valid entries |

## Verification
A probe value presented before clock edge k is registered at edge k and encoded at edge k+1. The resulting entry and the new count can therefore be read at the falling edge after k+1. A trigger raised before edge T makes the literal of the sample presented before T appear after edge T+1.

The bench sets inputs and samples outputs only on falling edges. After the last sample of a pattern it waits one extra cycle before it reads the status, and it issues abort only after that read. rd_data is combinational from the pointer, so each read is checked one falling edge after the edge that moved the pointer. Expected entry streams come from an arithmetic encoder in the bench, which is run over a sweep of run lengths.

// File: rtl/trace_probe.sv
module trace_probe #(
  parameter int W = 15,
  parameter int DEPTH = 64,
  parameter int RUN_MAX = 32767,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  probe_in,
  input  logic          trig_in,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          rd_en,
  output logic [15:0]   rd_data,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] count
);
  typedef enum logic [1:0] {IDLE, WAITING, RUNNING, FULL} state_t;

  state_t        state;
  logic [W-1:0]  probe_q, last;
  logic          trig_q, trig_d;
  logic [14:0]   run;
  logic [CW-1:0] wr;
  logic [AW-1:0] rd_ptr;
  logic [15:0]   mem [DEPTH];

  logic          we0, we1;
  logic [15:0]   wd0;
  logic [AW-1:0] wa0;
  logic [CW-1:0] wr_next;

  wire is_arm   = cmd_valid && cmd_op == 2'd1;
  wire is_abort = cmd_valid && cmd_op == 2'd2;
  wire is_rew   = cmd_valid && cmd_op == 2'd3;
  wire tedge    = trig_q && !trig_d;
  wire same     = probe_q == last;
  wire at_max   = run == 15'(RUN_MAX);
  wire [15:0] lit = {1'b0, 15'(probe_q)};

  always_comb begin
    we0 = 1'b0;
    we1 = 1'b0;
    wd0 = lit;
    wa0 = wr[AW-1:0];
    if (!is_arm && !is_abort) begin
      if (state == WAITING && tedge) begin
        we0 = 1'b1;
      end else if (state == RUNNING) begin
        if (same) begin
          if (at_max) begin
            we0 = 1'b1;
            wd0 = {1'b1, run};
          end
        end else if (run == '0) begin
          we0 = 1'b1;
        end else begin
          we0 = 1'b1;
          wd0 = {1'b1, run};
          we1 = wr != CW'(DEPTH - 1);
        end
      end
    end
  end

  assign wr_next = wr + CW'(we0) + CW'(we1);

  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa0 + AW'(1)] <= lit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      probe_q <= '0;
      last    <= '0;
      trig_q  <= 1'b0;
      trig_d  <= 1'b0;
      run     <= '0;
      wr      <= '0;
      rd_ptr  <= '0;
    end else begin
      probe_q <= probe_in;
      trig_q  <= trig_in;
      trig_d  <= trig_q;
      if (is_rew) rd_ptr <= '0;
      else if (rd_en) rd_ptr <= rd_ptr + AW'(1);
      if (is_arm) begin
        state <= WAITING;
        wr    <= '0;
        run   <= '0;
      end else if (is_abort) begin
        state <= IDLE;
      end else begin
        wr <= wr_next;
        if (state == WAITING && tedge) begin
          last  <= probe_q;
          run   <= '0;
          state <= RUNNING;
        end else if (state == RUNNING) begin
          if (same) begin
            run <= at_max ? 15'd1 : run + 15'd1;
          end else begin
            last <= probe_q;
            run  <= '0;
          end
        end
        if ((state == WAITING || state == RUNNING) && wr_next == CW'(DEPTH))
          state <= FULL;
      end
    end
  end

  assign rd_data = mem[rd_ptr];
  assign busy    = state == WAITING || state == RUNNING;
  assign done    = state == FULL;
  assign count   = wr;

  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 15'(RUN_MAX)); // R4
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R6
  AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_arm) |=> count == $past(count)); // R6
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    is_arm |=> (count == '0 && busy && !done)); // R5
  AST_FIRST_LITERAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WAITING && tedge && !is_arm && !is_abort) |=> (!mem[0][15] && count == CW'(1))); // R2
  AST_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    is_rew |=> rd_ptr == '0); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_abort && !is_arm) |=> (!busy && !done && count == $past(count))); // R7
endmodule

// File: tb/trace_probe_test.sv
module trace_probe_test;
  localparam int W = 15, DEPTH = 16, RMAX = 5, CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [W-1:0] probe_in = '0;
  logic trig_in = 0, cmd_valid = 0, rd_en = 0;
  logic [1:0] cmd_op = '0;
  logic [15:0] rd_data;
  logic busy, done;
  logic [CW-1:0] count;

  int checks = 0, errors = 0;
  logic [15:0] expv [DEPTH];
  int exp_n;

  trace_probe #(.W(W), .DEPTH(DEPTH), .RUN_MAX(RMAX)) uut (
    .clk(clk), .rst_n(rst_n), .probe_in(probe_in), .trig_in(trig_in),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .rd_en(rd_en), .rd_data(rd_data),
    .busy(busy), .done(done), .count(count));

  always #2 clk = ~clk;

  task automatic check(string req, int act, int expct);
    checks++;
    if (act != expct) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expct);
    end
  endtask

  function automatic logic [W-1:0] val(int len, int i);
    return W'((((i / len) + 1) * 32'h0923) ^ (len << 10));
  endfunction

  function automatic void push(logic [15:0] e);
    if (exp_n < DEPTH) begin
      expv[exp_n] = e;
      exp_n++;
    end
  endfunction

  function automatic void model(int len, int m);
    int run = 0;
    logic [W-1:0] last = '0;
    exp_n = 0;
    for (int i = 0; i < m && exp_n < DEPTH; i++) begin
      logic [W-1:0] v = val(len, i);
      if (i == 0) begin push({1'b0, 15'(v)}); last = v; end
      else if (v == last) begin
        if (run == RMAX) begin push({1'b1, 15'(run)}); run = 1; end
        else run++;
      end else begin
        if (run > 0) push({1'b1, 15'(run)});
        push({1'b0, 15'(v)});
        run = 0;
        last = v;
      end
    end
  endfunction

  task automatic command(logic [1:0] op);
    cmd_valid = 1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 0; cmd_op = '0;
  endtask

  task automatic read_back(int n, string req);
    command(2'd3);
    rd_en = 1;
    for (int j = 0; j < n; j++) begin
      check(req, rd_data, expv[j]);
      @(negedge clk);
    end
    rd_en = 0;
  endtask

  task automatic pattern(int len, int m);
    trig_in = 0;
    command(2'd1);
    check("R5 busy after arm", busy, 1);
    check("R5 count after arm", count, 0);
    @(negedge clk);
    check("R5 no write before trigger", count, 0);
    for (int i = 0; i < m; i++) begin
      probe_in = val(len, i); trig_in = 1;
      @(negedge clk);
    end
    @(negedge clk);
    model(len, m);
    check("R6 done flag", done, exp_n == DEPTH);
    check("R6 busy flag", busy, exp_n != DEPTH);
    check("R3 entry count", count, exp_n);
    command(2'd2);
    check("R7 idle after abort", busy | done, 0);
    check("R7 count kept", count, exp_n);
    read_back(exp_n, "R1 R3 R4 entry");
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("reset busy", busy, 0);
    check("reset done", done, 0);
    check("reset count", count, 0);

    for (int len = 1; len <= 7; len++) pattern(len, 20);
    pattern(20, 20);
    pattern(2, 40);

    // R5: trigger already high at arm
    trig_in = 1; probe_in = 15'h1234;
    @(negedge clk); @(negedge clk);
    command(2'd1);
    repeat (4) @(negedge clk);
    check("R5 held trigger ignored", count, 0);
    trig_in = 0; @(negedge clk);
    probe_in = 15'h0abc; trig_in = 1; @(negedge clk);
    probe_in = 15'h0abc; @(negedge clk);
    check("R2 first literal count", count, 1);
    command(2'd2);
    // R7: changes after abort write nothing
    for (int i = 0; i < 4; i++) begin probe_in = 15'(i * 7 + 1); @(negedge clk); end
    check("R7 no writes after abort", count, 1);
    expv[0] = {1'b0, 15'h0abc};
    read_back(1, "R2 first literal value");

    // R8: pointer advance and rewind priority
    pattern(1, 20);
    rd_en = 1; @(negedge clk); @(negedge clk);
    check("R8 pointer advanced", rd_data, expv[2]);
    cmd_valid = 1; cmd_op = 2'd3; @(negedge clk);
    cmd_valid = 0; rd_en = 0;
    check("R8 rewind beats rd_en", rd_data, expv[0]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule